// File: doc/BRIEF.md
# Ordered Four-Stream Packet Merger

This block takes packets arriving on four independent 16-bit input streams and merges them into one 32-bit output stream. Each stream has its own buffer that packs pairs of half-words into 32-bit words. A separate queue of ordering records says which stream holds the next packet. The merger follows that queue strictly, so packets leave in the order in which they first arrived upstream, whatever order the four streams happen to fill in.

The first 32-bit word of every packet is its control word. The merger takes this word off the data path and places it in a control FIFO, in record order. A consumer first reads the control word. It then either reads the packet's remaining words from the data output, or asks for the packet to be discarded. A discard flushes the rest of the packet from its buffer at one word per cycle without presenting it. A packet must carry at least two half-words, which form its control word.

Top module: `pkt_reorder_merge`

## Requirements
- R1: On each stream, consecutive half-words of a packet are packed into 32-bit words, with the earlier half-word in bits 31:16 and the later one in bits 15:0. Packing restarts at every packet boundary.
- R2: A packet with an odd number of half-words ends in a word whose bits 15:0 are zero and whose byte-valid flag `out_be` is 4'b1100. Every other word carries `out_be` = 4'b1111.
- R3: Each ordering record is a 2-bit stream index (0 to 3). Packets are presented in the order of the records. A record is retired only when its packet's last word has left the buffer.
- R4: The first 32-bit word of each packet (half-words 0 and 1) goes to the control FIFO and never to the data output. Control words come out in record order.
- R5: `out_last` is high on the final data word of each packet and low on all others.
- R6: A one-cycle `pkt_drop` pulse while a packet body is selected discards that packet's remaining words, including any word offered in the same cycle, even if `out_ready` is high. One word is removed per cycle while `out_valid` stays low, and the next packet then follows unaffected.
- R7: If the stream named by the head record has no data, the merger stalls: no control word and no data are presented, even when other streams hold packets.
- R8: While `out_valid` is high and `out_ready` is low (and no drop is requested), `out_valid` stays high and `out_data` stays unchanged.
- R9: A stream's `in_ready` goes low when its buffer is full. No accepted half-word is lost.
- R10: After reset, `out_valid` and `ctrl_valid` are low, while `ord_ready` and all `in_ready` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 4 | Per-stream half-word valid |
| in_ready | output | 4 | Per-stream ready; low while that stream's buffer is full |
| in_data | input | 64 | Stream s half-word on bits 16s+15:16s |
| in_last | input | 4 | Per-stream last half-word of packet |
| ord_valid | input | 1 | Ordering record valid |
| ord_ready | output | 1 | Ordering queue has room |
| ord_stream | input | 2 | Stream index holding the next packet |
| out_valid | output | 1 | Data word valid |
| out_ready | input | 1 | Consumer takes the data word |
| out_data | output | 32 | Merged data word |
| out_be | output | 4 | Byte-valid flags of the data word |
| out_last | output | 1 | Final word of the packet |
| pkt_drop | input | 1 | Discard the rest of the current packet |
| ctrl_valid | output | 1 | Control word available |
| ctrl_ready | input | 1 | Consumer takes the control word |
| ctrl_data | output | 32 | Control word of a packet, in record order |

## Verification
A discard request can arrive in the same cycle in which the consumer accepts a data word. The bench raises `pkt_drop` together with `out_ready` on a valid first body word. It then checks that `out_valid` stays low while the flush runs, and that the next word delivered is the first body word of the following packet on the same stream. A second collision is a stream buffer being filled and drained in the same cycles. To provoke it, five long packets are sent on one stream while the consumer starts late. The bench requires that `in_ready` was seen low at least once and that every word still arrives intact and in order.

// File: rtl/pkt_merge_pkg.sv
// Shared constants and types for the ordered four-stream packet merger.
package pkt_merge_pkg;
    localparam int NUM_STREAMS = 4;
    localparam int HALF_W      = 16;
    localparam int WORD_W      = 2 * HALF_W;
    localparam int BE_W        = WORD_W / 8;
    localparam int SEL_W       = $clog2(NUM_STREAMS);

    // One packed word as held in a stream buffer.
    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [BE_W-1:0]   be;
        logic [WORD_W-1:0] data;
    } beat_t;

    typedef enum logic {ST_HDR, ST_BODY} mst_t;
endpackage

// File: rtl/pkt_sync_fifo.sv
// Synchronous FIFO with a combinational head read.
// Assumes DEPTH is a power of two; callers never push when full or pop when empty.
module pkt_sync_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wptr, rptr;

    assign rdata = mem[rptr[AW-1:0]];
    assign empty = (wptr == rptr);
    assign full  = (wptr[AW-1:0] == rptr[AW-1:0]) && (wptr[AW] != rptr[AW]);

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wptr[AW-1:0]] <= wdata;
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R7
endmodule

// File: rtl/pkt_widen_buf.sv
// Per-stream buffer: packs 16-bit half-words into 32-bit words and queues them.
// The earlier half-word goes in the upper half. A packet ending on an odd half-word
// gets a zero lower half and byte flags 4'b1100. Each word records whether it is
// the first (sop) or the last (eop) word of its packet.
module pkt_widen_buf
    import pkt_merge_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [HALF_W-1:0] s_data,
    input  logic              s_last,
    input  logic              rd_pop,
    output beat_t             rd_beat,
    output logic              rd_empty
);
    localparam int BW = $bits(beat_t);

    logic [HALF_W-1:0] hi_q;
    logic              odd_q;
    logic              sop_q;
    logic              full;
    logic              accept, push;
    beat_t             wbeat;
    logic [BW-1:0]     wvec, rvec;

    assign s_ready = !full;
    assign accept  = s_valid && s_ready;
    assign push    = accept && (odd_q || s_last);

    // Form the word to queue from the held half and the incoming half.
    always_comb begin
        wbeat.sop  = sop_q;
        wbeat.eop  = s_last;
        wbeat.be   = odd_q ? 4'b1111 : 4'b1100;
        wbeat.data = odd_q ? {hi_q, s_data} : {s_data, {HALF_W{1'b0}}};
    end
    assign wvec    = wbeat;
    assign rd_beat = beat_t'(rvec);

    // Half-word pairing state and packet-start tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            odd_q <= 1'b0;
            sop_q <= 1'b1;
        end else if (accept) begin
            if (push) begin
                odd_q <= 1'b0;
                sop_q <= s_last;
            end else begin
                hi_q  <= s_data;
                odd_q <= 1'b1;
            end
        end
    end

    pkt_sync_fifo #(.WIDTH(BW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (wvec),
        .pop   (rd_pop),
        .rdata (rvec),
        .empty (rd_empty),
        .full  (full)
    );

    AST_PAD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !odd_q) |-> (wvec[HALF_W-1:0] == '0));  // R2
endmodule

// File: rtl/pkt_reorder_merge.sv
// Top: four widening stream buffers, a queue of ordering records and a control FIFO.
// The head record selects one stream. The first word of that stream's packet moves
// to the control FIFO, and the body is then offered on the output or flushed on a
// drop. The record retires on the packet's last word. Assumes every packet has at
// least two half-words and that records name streams that will receive the packet.
module pkt_reorder_merge
    import pkt_merge_pkg::*;
#(
    parameter int BUF_DEPTH  = 8,
    parameter int ORD_DEPTH  = 4,
    parameter int CTRL_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_STREAMS-1:0]      in_valid,
    output logic [NUM_STREAMS-1:0]      in_ready,
    input  logic [NUM_STREAMS*HALF_W-1:0] in_data,
    input  logic [NUM_STREAMS-1:0]      in_last,
    input  logic                        ord_valid,
    output logic                        ord_ready,
    input  logic [SEL_W-1:0]            ord_stream,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [WORD_W-1:0]           out_data,
    output logic [BE_W-1:0]             out_be,
    output logic                        out_last,
    input  logic                        pkt_drop,
    output logic                        ctrl_valid,
    input  logic                        ctrl_ready,
    output logic [WORD_W-1:0]           ctrl_data
);
    beat_t                  head  [NUM_STREAMS];
    logic [NUM_STREAMS-1:0] buf_empty;
    logic [NUM_STREAMS-1:0] buf_pop;

    logic [SEL_W-1:0] sel;
    logic             ord_empty, ord_full, ord_pop, ord_has;
    logic             ctrl_empty, ctrl_full;
    mst_t             state;
    logic             drop_q;
    beat_t            cur;
    logic             cur_ne, hdr_move, body_act, flushing, body_pop;

    // One widening buffer per input stream.
    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
        pkt_widen_buf #(.DEPTH(BUF_DEPTH)) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .s_valid  (in_valid[g]),
            .s_ready  (in_ready[g]),
            .s_data   (in_data[g*HALF_W +: HALF_W]),
            .s_last   (in_last[g]),
            .rd_pop   (buf_pop[g]),
            .rd_beat  (head[g]),
            .rd_empty (buf_empty[g])
        );
    end

    pkt_sync_fifo #(.WIDTH(SEL_W), .DEPTH(ORD_DEPTH)) u_ord (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ord_valid && ord_ready),
        .wdata (ord_stream),
        .pop   (ord_pop),
        .rdata (sel),
        .empty (ord_empty),
        .full  (ord_full)
    );

    pkt_sync_fifo #(.WIDTH(WORD_W), .DEPTH(CTRL_DEPTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (hdr_move),
        .wdata (cur.data),
        .pop   (ctrl_ready && ctrl_valid),
        .rdata (ctrl_data),
        .empty (ctrl_empty),
        .full  (ctrl_full)
    );

    assign ord_ready  = !ord_full;
    assign ord_has    = !ord_empty;
    assign ctrl_valid = !ctrl_empty;

    // Selection, control capture, body delivery and flush decisions.
    always_comb begin
        cur      = head[sel];
        cur_ne   = !buf_empty[sel];
        hdr_move = (state == ST_HDR) && ord_has && cur_ne && !ctrl_full;
        body_act = (state == ST_BODY) && ord_has && cur_ne;
        flushing = drop_q || ((state == ST_BODY) && pkt_drop);
        body_pop = body_act && (flushing || out_ready);
        ord_pop  = (hdr_move || body_pop) && cur.eop;
        for (int i = 0; i < NUM_STREAMS; i++) begin
            buf_pop[i] = (sel == SEL_W'(i)) && (hdr_move || body_pop);
        end
    end

    assign out_valid = body_act && !flushing;
    assign out_data  = cur.data;
    assign out_be    = cur.be;
    assign out_last  = cur.eop;

    // Packet phase and latched drop request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_HDR;
            drop_q <= 1'b0;
        end else if (hdr_move && !cur.eop) begin
            state  <= ST_BODY;
        end else if (body_pop && cur.eop) begin
            state  <= ST_HDR;
            drop_q <= 1'b0;
        end else if ((state == ST_BODY) && pkt_drop) begin
            drop_q <= 1'b1;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !pkt_drop) |=> ((out_valid || pkt_drop) && $stable(out_data)));  // R8
    AST_HDR_IS_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_move |-> cur.sop);  // R4
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ord_has && !ord_pop) |=> $stable(sel));  // R3
    AST_BODY_HAS_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY) |-> ord_has);  // R5
endmodule

// File: tb/sim_pkt_reorder_merge.sv
module sim_pkt_reorder_merge;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  in_valid = '0;
    logic [3:0]  in_ready;
    logic [63:0] in_data = '0;
    logic [3:0]  in_last = '0;
    logic        ord_valid = 1'b0;
    logic        ord_ready;
    logic [1:0]  ord_stream = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  out_be;
    logic        out_last;
    logic        pkt_drop = 1'b0;
    logic        ctrl_valid;
    logic        ctrl_ready = 1'b0;
    logic [31:0] ctrl_data;

    int n_chk = 0;
    int n_fail = 0;
    bit saw_block = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_reorder_merge u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .ord_valid(ord_valid), .ord_ready(ord_ready), .ord_stream(ord_stream),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_be(out_be), .out_last(out_last), .pkt_drop(pkt_drop),
        .ctrl_valid(ctrl_valid), .ctrl_ready(ctrl_ready), .ctrl_data(ctrl_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] hw(input int s, input int p, input int i);
        return 16'((s + 1) * 4096 + (p % 64) * 64 + i + 1);
    endfunction

    task automatic send_half(input int s, input logic [15:0] d, input bit last);
        forever begin
            @(negedge clk);
            in_valid[s] = 1'b1;
            in_data[s*16 +: 16] = d;
            in_last[s] = last;
            if (in_ready[s]) break;
            saw_block = 1;
        end
    endtask

    task automatic send_pkt(input int s, input int p, input int len);
        for (int i = 0; i < len; i++) send_half(s, hw(s, p, i), i == len - 1);
        @(negedge clk);
        in_valid[s] = 1'b0;
        in_last[s] = 1'b0;
    endtask

    task automatic send_rec(input int s);
        forever begin
            @(negedge clk);
            ord_valid = 1'b1;
            ord_stream = 2'(s);
            if (ord_ready) break;
        end
        @(negedge clk);
        ord_valid = 1'b0;
    endtask

    task automatic recv_ctrl(input int s, input int p);
        forever begin
            @(negedge clk);
            if (ctrl_valid) break;
        end
        check(ctrl_data == {hw(s, p, 0), hw(s, p, 1)}, "R4 control word", ctrl_data, {hw(s, p, 0), hw(s, p, 1)});
        ctrl_ready = 1'b1;
        @(negedge clk);
        ctrl_ready = 1'b0;
    endtask

    task automatic recv_body(input int s, input int p, input int len, input int k0);
        for (int k = k0; 2 + 2 * k < len; k++) begin
            logic [31:0] ed;
            logic [3:0]  eb;
            bit          el;
            ed = {hw(s, p, 2 + 2 * k), (3 + 2 * k < len) ? hw(s, p, 3 + 2 * k) : 16'h0};
            eb = (3 + 2 * k < len) ? 4'b1111 : 4'b1100;
            el = (4 + 2 * k >= len);
            forever begin
                @(negedge clk);
                if (out_valid) break;
            end
            check(out_data == ed, "R1/R3 data word", out_data, ed);
            check(out_be == eb, "R2 byte flags", out_be, eb);
            check(out_last == el, "R5 last flag", out_last, el);
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
        check(ctrl_valid == 1'b0, "R10 ctrl_valid", ctrl_valid, 0);
        check(ord_ready == 1'b1, "R10 ord_ready", ord_ready, 1);
        check(in_ready == 4'hF, "R10 in_ready", in_ready, 4'hF);
        rst_n = 1'b1;

        // Sweep: every order of the four streams, mixed odd/even lengths (R1 R2 R3 R4 R5)
        for (int r = 0; r < 24; r++) begin
            int avail[4];
            int perm[4];
            int rem;
            int lens[4];
            rem = r;
            for (int j = 0; j < 4; j++) avail[j] = j;
            for (int k = 0; k < 4; k++) begin
                int idx;
                idx = rem % (4 - k);
                rem = rem / (4 - k);
                perm[k] = avail[idx];
                for (int j = idx; j < 3; j++) avail[j] = avail[j + 1];
            end
            for (int s = 0; s < 4; s++) lens[s] = 3 + ((r * 5 + s * 3) % 6);
            for (int s = 0; s < 4; s++) send_pkt(s, r, lens[s]);
            for (int k = 0; k < 4; k++) send_rec(perm[k]);
            for (int k = 0; k < 4; k++) begin
                recv_ctrl(perm[k], r);
                recv_body(perm[k], r, lens[perm[k]], 0);
            end
        end

        // R7: head record names an empty stream; stream 0 holds data but must wait
        send_rec(3);
        send_rec(0);
        send_pkt(0, 41, 6);
        repeat (10) @(negedge clk);
        check(ctrl_valid == 1'b0, "R7 no control while stalled", ctrl_valid, 0);
        check(out_valid == 1'b0, "R7 no data while stalled", out_valid, 0);
        send_pkt(3, 42, 7);
        recv_ctrl(3, 42);
        recv_body(3, 42, 7, 0);
        recv_ctrl(0, 41);
        recv_body(0, 41, 6, 0);

        // R6: drop in the same cycle as an accepted read, then a packet behind it
        send_pkt(2, 43, 8);
        send_pkt(2, 44, 5);
        send_rec(2);
        send_rec(2);
        recv_ctrl(2, 43);
        forever begin
            @(negedge clk);
            if (out_valid) break;
        end
        out_ready = 1'b1;
        pkt_drop = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        pkt_drop = 1'b0;
        check(out_valid == 1'b0, "R6 quiet during flush", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R6 quiet during flush", out_valid, 0);
        recv_ctrl(2, 44);
        recv_body(2, 44, 5, 0);

        // R8: hold the output under backpressure
        send_pkt(1, 45, 8);
        send_rec(1);
        recv_ctrl(1, 45);
        forever begin
            @(negedge clk);
            if (out_valid) break;
        end
        begin
            logic [31:0] held;
            held = out_data;
            for (int t = 0; t < 4; t++) begin
                @(negedge clk);
                check(out_valid == 1'b1, "R8 valid held", out_valid, 1);
                check(out_data == held, "R8 data held", out_data, held);
            end
        end
        recv_body(1, 45, 8, 0);

        // R9: overfill one stream while the consumer starts late
        saw_block = 0;
        fork
            begin
                for (int p = 50; p < 55; p++) send_pkt(1, p, 8);
            end
            begin
                for (int p = 50; p < 55; p++) send_rec(1);
            end
            begin
                repeat (60) @(negedge clk);
                for (int p = 50; p < 55; p++) begin
                    recv_ctrl(1, p);
                    recv_body(1, p, 8, 0);
                end
            end
        join
        check(saw_block == 1, "R9 in_ready deasserted when full", saw_block, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule